// File: doc/BRIEF.md
# Conditional Jump Evaluator

This block resolves one instruction from the relative conditional jump group of a 16-bit processor. It takes the opcode word, the program counter that already points past the jump instruction, and six status flags: logical-greater, arithmetic-greater, equal, carry, overflow and parity. From these it decides whether the jump is taken and produces the next program counter and the number of cycles the instruction costs. The sequencer uses these outputs to load the PC and to charge the cycle budget.

The opcode group is identified by bits 15:12 equal to 1. Bits 11:8 select one of thirteen conditions, and bits 7:0 hold a signed word displacement. Codes 13 to 15 in the same group are bit-level I/O operations and not jumps, so the block reports them as non-jumps. The decision logic is combinational. A parameter adds an output register stage. With the default setting the outputs follow the inputs by one clock.

Top module: `jump_resolver`

## Requirements
- R1: `is_jump` is 1 exactly when opcode bits 15:12 equal 4'h1 and opcode bits 11:8 are in the range 0 to 12.
- R2: When `is_jump` is 0, whether for codes 13 to 15 or for another opcode group, `taken` is 0, `cycle_cnt` is 0 and `target_pc` is the incremented PC with bit 0 cleared, whatever the flags are.
- R3: Code 0 is taken for any flag values.
- R4: Code 1 (signed less) is taken when arithmetic-greater and equal are both 0. Code 5 (signed greater) is taken when arithmetic-greater is 1.
- R5: Code 10 (unsigned lower) is taken when logical-greater and equal are both 0. Code 11 (unsigned higher) is taken when logical-greater is 1 and equal is 0. Code 4 (unsigned higher-or-equal) is taken when logical-greater or equal is 1. Code 2 (unsigned lower-or-equal) is taken when logical-greater is 0 or equal is 1.
- R6: Code 3 is taken when equal is 1. Code 6 is taken when equal is 0.
- R7: Code 7 is taken when carry is 0 and code 8 when carry is 1. Code 9 is taken when overflow is 0. Code 12 is taken when parity is 1.
- R8: A taken jump gives `target_pc` = (incremented PC + 2 × sign-extended opcode bits 7:0) modulo 2^16, with bit 0 cleared. A jump that is not taken gives the incremented PC with bit 0 cleared.
- R9: `target_pc` bit 0 is always 0.
- R10: `cycle_cnt` is 8 for a jump that is not taken and 10 for a taken jump.
- R11: With output registering enabled (the default), the outputs reflect the inputs sampled at the previous rising clock edge. A synchronous active-high reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_word | input | 16 | Instruction opcode word |
| pc_inc | input | 16 | Program counter already advanced past the jump |
| flag_lgt | input | 1 | Logical-greater status flag |
| flag_agt | input | 1 | Arithmetic-greater status flag |
| flag_eq | input | 1 | Equal status flag |
| flag_cy | input | 1 | Carry status flag |
| flag_ov | input | 1 | Overflow status flag |
| flag_par | input | 1 | Parity status flag |
| is_jump | output | 1 | Opcode is one of the thirteen jump conditions |
| taken | output | 1 | Jump condition met |
| target_pc | output | 16 | Next program counter |
| cycle_cnt | output | 4 | Cycles charged for the instruction |

## Verification
Condition evaluation and address wrap-around can occur in the same cycle: a taken jump whose displacement carries the target across the 0xFFFF/0x0000 boundary. The bench provokes this with an incremented PC near the top of memory and a positive displacement, and with a PC near zero and a negative displacement. In each of these cycles it checks together that `taken` is 1, that `cycle_cnt` is 10 and that `target_pc` holds the wrapped value. It also uses an odd PC to check that bit 0 is cleared both when the jump is taken and when it is not.

// File: rtl/jr_pkg.sv
package jr_pkg;

    typedef struct packed {
        logic lgt;
        logic agt;
        logic eq;
        logic cy;
        logic ov;
        logic par;
    } jr_flags_t;

    typedef enum logic [3:0] {
        JC_ALWAYS = 4'd0,
        JC_SLT    = 4'd1,
        JC_ULE    = 4'd2,
        JC_EQ     = 4'd3,
        JC_UGE    = 4'd4,
        JC_SGT    = 4'd5,
        JC_NE     = 4'd6,
        JC_NCY    = 4'd7,
        JC_CY     = 4'd8,
        JC_NOV    = 4'd9,
        JC_ULT    = 4'd10,
        JC_UGT    = 4'd11,
        JC_PAR    = 4'd12,
        JC_IO0    = 4'd13,
        JC_IO1    = 4'd14,
        JC_IO2    = 4'd15
    } jr_cond_e;

    localparam logic [3:0] JR_GROUP     = 4'h1;
    localparam logic [3:0] JR_LAST_JUMP = 4'd12;

    typedef struct packed {
        logic     is_jump;
        jr_cond_e cond;
        logic [7:0] disp;
    } jr_dec_t;

    function automatic logic jr_cond_met(jr_cond_e c, jr_flags_t f);
        logic m;
        case (c)
            JC_ALWAYS: m = 1'b1;
            JC_SLT:    m = ~f.agt & ~f.eq;
            JC_ULE:    m = ~f.lgt | f.eq;
            JC_EQ:     m = f.eq;
            JC_UGE:    m = f.lgt | f.eq;
            JC_SGT:    m = f.agt;
            JC_NE:     m = ~f.eq;
            JC_NCY:    m = ~f.cy;
            JC_CY:     m = f.cy;
            JC_NOV:    m = ~f.ov;
            JC_ULT:    m = ~f.lgt & ~f.eq;
            JC_UGT:    m = f.lgt & ~f.eq;
            JC_PAR:    m = f.par;
            default:   m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/jr_decode.sv
module jr_decode
    import jr_pkg::*;
#(
    parameter int OP_W = 16
) (
    input  logic [OP_W-1:0] op,
    output jr_dec_t         dec
);
    logic [3:0] grp;
    logic [3:0] code;

    assign grp  = op[OP_W-1 -: 4];
    assign code = op[11:8];

    always_comb begin
        dec.cond    = jr_cond_e'(code);
        dec.disp    = op[7:0];
        dec.is_jump = (grp == JR_GROUP) && (code <= JR_LAST_JUMP);
    end
endmodule

// File: rtl/jr_cond.sv
module jr_cond
    import jr_pkg::*;
(
    input  jr_dec_t   dec,
    input  jr_flags_t flags,
    output logic      met
);
    assign met = dec.is_jump & jr_cond_met(dec.cond, flags);
endmodule

// File: rtl/jr_target.sv
module jr_target #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [7:0]        disp,
    input  logic              take,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - 9;

    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] nxt;

    assign offs   = {{EXT_W{disp[7]}}, disp, 1'b0};
    assign sum    = pc + offs;
    assign nxt    = take ? sum : pc;
    assign target = {nxt[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
    import jr_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OP_W      = 16,
    parameter int CYC_W     = 4,
    parameter int BASE_CYC  = 8,
    parameter int TAKEN_CYC = 2,
    parameter bit REG_OUT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_word,
    input  logic [ADDR_W-1:0] pc_inc,
    input  logic              flag_lgt,
    input  logic              flag_agt,
    input  logic              flag_eq,
    input  logic              flag_cy,
    input  logic              flag_ov,
    input  logic              flag_par,
    output logic              is_jump,
    output logic              taken,
    output logic [ADDR_W-1:0] target_pc,
    output logic [CYC_W-1:0]  cycle_cnt
);
    localparam logic [CYC_W-1:0] CYC_NT = CYC_W'(BASE_CYC);
    localparam logic [CYC_W-1:0] CYC_TK = CYC_W'(BASE_CYC + TAKEN_CYC);

    jr_flags_t         flags;
    jr_dec_t           dec;
    logic              met;
    logic [ADDR_W-1:0] tgt;
    logic [CYC_W-1:0]  cyc;

    assign flags = '{lgt: flag_lgt, agt: flag_agt, eq: flag_eq,
                     cy: flag_cy, ov: flag_ov, par: flag_par};

    jr_decode #(.OP_W(OP_W)) u_dec (
        .op  (op_word),
        .dec (dec)
    );

    jr_cond u_cond (
        .dec   (dec),
        .flags (flags),
        .met   (met)
    );

    jr_target #(.ADDR_W(ADDR_W)) u_tgt (
        .pc     (pc_inc),
        .disp   (dec.disp),
        .take   (met),
        .target (tgt)
    );

    assign cyc = !dec.is_jump ? '0 : (met ? CYC_TK : CYC_NT);

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    is_jump   <= 1'b0;
                    taken     <= 1'b0;
                    target_pc <= '0;
                    cycle_cnt <= '0;
                end else begin
                    is_jump   <= dec.is_jump;
                    taken     <= met;
                    target_pc <= tgt;
                    cycle_cnt <= cyc;
                end
            end
        end else begin : g_comb
            assign is_jump   = dec.is_jump;
            assign taken     = met;
            assign target_pc = tgt;
            assign cycle_cnt = cyc;
        end
    endgenerate
endmodule

// File: rtl/jr_checker.sv
module jr_checker #(
    parameter int ADDR_W    = 16,
    parameter int OP_W      = 16,
    parameter int CYC_W     = 4,
    parameter int BASE_CYC  = 8,
    parameter int TAKEN_CYC = 2,
    parameter bit REG_OUT   = 1'b1
) (
    input logic              clk,
    input logic              rst,
    input logic [OP_W-1:0]   op_word,
    input logic              flag_cy,
    input logic              is_jump,
    input logic              taken,
    input logic [ADDR_W-1:0] target_pc,
    input logic [CYC_W-1:0]  cycle_cnt
);
    AST_NONJUMP_QUIET: assert property (@(posedge clk) disable iff (rst)
        !is_jump |-> (!taken && cycle_cnt == '0)); // R2

    AST_TARGET_EVEN: assert property (@(posedge clk) disable iff (rst)
        target_pc[0] == 1'b0); // R9

    AST_TAKEN_COST: assert property (@(posedge clk) disable iff (rst)
        (is_jump && taken) |-> cycle_cnt == CYC_W'(BASE_CYC + TAKEN_CYC)); // R10

    AST_IDLE_COST: assert property (@(posedge clk) disable iff (rst)
        (is_jump && !taken) |-> cycle_cnt == CYC_W'(BASE_CYC)); // R10

    generate
        if (REG_OUT) begin : g_seq
            AST_IO_CODES: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_word[OP_W-1 -: 4] == 4'h1 && op_word[11:8] >= 4'd13))
                |-> !is_jump); // R1

            AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_word[OP_W-1 -: 8] == 8'h10)) |-> taken); // R3

            AST_CARRY_TAKEN: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(op_word[OP_W-1 -: 8] == 8'h18 && flag_cy)) |-> taken); // R7

            AST_RESET_CLEAR: assert property (@(posedge clk)
                rst |=> (!is_jump && !taken && target_pc == '0 && cycle_cnt == '0)); // R11
        end
    endgenerate
endmodule

bind jump_resolver jr_checker #(
    .ADDR_W(ADDR_W), .OP_W(OP_W), .CYC_W(CYC_W),
    .BASE_CYC(BASE_CYC), .TAKEN_CYC(TAKEN_CYC), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst(rst), .op_word(op_word), .flag_cy(flag_cy),
    .is_jump(is_jump), .taken(taken), .target_pc(target_pc), .cycle_cnt(cycle_cnt)
);

// File: tb/jump_resolver_bench.sv
module jump_resolver_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] op_word;
    logic [15:0] pc_inc;
    logic [5:0]  flg;
    logic        is_jump, taken;
    logic [15:0] target_pc;
    logic [3:0]  cycle_cnt;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    jump_resolver u_jump_resolver (
        .clk(clk), .rst(rst), .op_word(op_word), .pc_inc(pc_inc),
        .flag_lgt(flg[5]), .flag_agt(flg[4]), .flag_eq(flg[3]),
        .flag_cy(flg[2]), .flag_ov(flg[1]), .flag_par(flg[0]),
        .is_jump(is_jump), .taken(taken), .target_pc(target_pc), .cycle_cnt(cycle_cnt)
    );

    // {op, pc, flags{lgt,agt,eq,cy,ov,par}, jump, taken, target, cycles}
    localparam int NV = 18;
    localparam logic [59:0] VEC [NV] = '{
        {16'h1005, 16'h1000, 6'b000000, 1'b1, 1'b1, 16'h100A, 4'd10}, // R3
        {16'h11FE, 16'h1000, 6'b000000, 1'b1, 1'b1, 16'h0FFC, 4'd10}, // R4
        {16'h11FE, 16'h1000, 6'b001000, 1'b1, 1'b0, 16'h1000, 4'd8},  // R4
        {16'h1203, 16'h1000, 6'b100000, 1'b1, 1'b0, 16'h1000, 4'd8},  // R5
        {16'h1203, 16'h1000, 6'b101000, 1'b1, 1'b1, 16'h1006, 4'd10}, // R5
        {16'h1310, 16'h1000, 6'b001000, 1'b1, 1'b1, 16'h1020, 4'd10}, // R6
        {16'h1410, 16'h1000, 6'b000000, 1'b1, 1'b0, 16'h1000, 4'd8},  // R5
        {16'h157F, 16'h1000, 6'b010000, 1'b1, 1'b1, 16'h10FE, 4'd10}, // R4
        {16'h1680, 16'h1000, 6'b000000, 1'b1, 1'b1, 16'h0F00, 4'd10}, // R6
        {16'h1701, 16'h1000, 6'b000100, 1'b1, 1'b0, 16'h1000, 4'd8},  // R7
        {16'h1801, 16'h1000, 6'b000100, 1'b1, 1'b1, 16'h1002, 4'd10}, // R7
        {16'h1901, 16'h1000, 6'b000000, 1'b1, 1'b1, 16'h1002, 4'd10}, // R7
        {16'h1A01, 16'h1000, 6'b000000, 1'b1, 1'b1, 16'h1002, 4'd10}, // R5
        {16'h1B01, 16'h1000, 6'b101000, 1'b1, 1'b0, 16'h1000, 4'd8},  // R5
        {16'h1C01, 16'h1000, 6'b000001, 1'b1, 1'b1, 16'h1002, 4'd10}, // R7
        {16'h1D01, 16'h1000, 6'b111111, 1'b0, 1'b0, 16'h1000, 4'd0},  // R1 R2
        {16'h1FFF, 16'h1000, 6'b111111, 1'b0, 1'b0, 16'h1000, 4'd0},  // R1 R2
        {16'h2001, 16'h1000, 6'b111111, 1'b0, 1'b0, 16'h1000, 4'd0}   // R1 R2
    };

    function automatic string req_of(logic [15:0] op);
        if (op[15:12] != 4'h1 || op[11:8] > 4'd12) return "R2";
        case (op[11:8])
            4'd0:                return "R3";
            4'd1, 4'd5:          return "R4";
            4'd3, 4'd6:          return "R6";
            4'd7, 4'd8, 4'd9, 4'd12: return "R7";
            default:             return "R5";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // drive at a falling edge; outputs are registered at the next rising edge (R11)
    task automatic apply(logic [15:0] op, logic [15:0] pc, logic [5:0] f);
        op_word = op;
        pc_inc  = pc;
        flg     = f;
        @(negedge clk);
    endtask

    task automatic judge(string req, logic j, logic t, logic [15:0] tg, logic [3:0] c);
        chk(req, "is_jump", 16'(is_jump), 16'(j));
        chk(req, "taken", 16'(taken), 16'(t));
        chk(req, "target_pc", target_pc, tg);
        chk("R10", "cycle_cnt", 16'(cycle_cnt), 16'(c));
        chk("R9", "target_bit0", 16'(target_pc[0]), 16'd0);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        op_word = 16'h1000;
        pc_inc = 16'h1234;
        flg = 6'b111111;
        repeat (3) @(negedge clk);
        // R11: reset clears every output even with a taken jump at the inputs
        judge("R11", 1'b0, 1'b0, 16'h0000, 4'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][59:44], VEC[i][43:28], VEC[i][27:22]);
            judge(req_of(VEC[i][59:44]), VEC[i][21], VEC[i][20], VEC[i][19:4], VEC[i][3:0]);
        end

        // R8: wrap past the top of memory, taken, in one cycle
        apply(16'h1010, 16'hFFFE, 6'b000000);
        judge("R8", 1'b1, 1'b1, 16'h001E, 4'd10);
        // R8: wrap below zero with a negative displacement
        apply(16'h1080, 16'h0002, 6'b000000);
        judge("R8", 1'b1, 1'b1, 16'hFF02, 4'd10);
        // R8: odd PC, taken, bit 0 cleared
        apply(16'h1002, 16'h1001, 6'b000000);
        judge("R8", 1'b1, 1'b1, 16'h1004, 4'd10);
        // R8: odd PC, parity clear so not taken, bit 0 cleared
        apply(16'h1C00, 16'h1001, 6'b000000);
        judge("R8", 1'b1, 1'b0, 16'h1000, 4'd8);
        // R3: code 0 with every flag set
        apply(16'h10FF, 16'h4000, 6'b111111);
        judge("R3", 1'b1, 1'b1, 16'h3FFE, 4'd10);
        // R4: signed greater not taken when arithmetic-greater is clear
        apply(16'h1501, 16'h1000, 6'b101111);
        judge("R4", 1'b1, 1'b0, 16'h1000, 4'd8);
        // R7: overflow set blocks code 9; carry set blocks code 7
        apply(16'h1901, 16'h1000, 6'b000010);
        judge("R7", 1'b1, 1'b0, 16'h1000, 4'd8);
        // R2: I/O code 14 with all flags set stays quiet
        apply(16'h1E01, 16'h2222, 6'b111111);
        judge("R2", 1'b0, 1'b0, 16'h2222, 4'd0);
        // R11: mid-run reset clears outputs
        rst = 1'b1;
        apply(16'h1005, 16'h1000, 6'b000000);
        judge("R11", 1'b0, 1'b0, 16'h0000, 4'd0);
        rst = 1'b0;
        apply(16'h1005, 16'h1000, 6'b000000);
        judge("R11", 1'b1, 1'b1, 16'h100A, 4'd10);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule